// File: doc/BRIEF.md
# Overlapping Frame Windowing Unit

This block sits between an audio sample source and a spectral transform stage. It accepts a stream of signed 16-bit samples through a valid/ready handshake and cuts it into analysis frames of `FRAME_LEN` samples. A new frame begins every `HOP` samples, with `HOP` smaller than `FRAME_LEN`. Successive frames therefore share `FRAME_LEN - HOP` samples, and each buffered sample is read out again for every frame that covers it. With the defaults (256-sample frames, a hop of 100, audio at 8 kHz) one frame covers roughly 30 ms.

Each sample leaving the block is scaled by a Hamming taper chosen by its position inside the frame. This attenuates the frame edges before the transform. The taper values are built into a coefficient table when the design is elaborated. The samples are kept in a circular buffer of `DEPTH` entries, where `DEPTH` is a power of two and at least `FRAME_LEN`. When the buffer holds `DEPTH` samples that are still needed, the input is held off.

The output is a windowed sample stream with a start-of-frame flag and an end-of-frame flag. Once a frame begins, its samples come out one per clock cycle. If enough samples are already buffered for the next frame, that frame follows with no idle cycle.

Top module: `frame_taper`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0. No output appears until `FRAME_LEN` samples have been accepted. The first `out_sof` comes 3 clock edges after the edge that accepts sample number `FRAME_LEN`.
- R2: Each frame is `FRAME_LEN` consecutive cycles with `out_valid` = 1. `out_sof` is 1 only on window index 0 and `out_eof` is 1 only on index `FRAME_LEN-1`. There are no gaps inside a frame.
- R3: Frame k, counted from 0 after reset, carries the accepted samples k·`HOP` through k·`HOP`+`FRAME_LEN`-1, in order. No frame is emitted before its last sample has been accepted.
- R4: Each output sample equals (s·c + 2^14) >> 15, using an arithmetic shift, where s is the signed input sample. The coefficient c is the integer obtained by rounding 32768·(0.54 − 0.46·cos(2πn/(`FRAME_LEN`−1))) half up, where n is the window index. The result is a signed 16-bit value.
- R5: `in_ready` is 0 exactly while the buffer holds `DEPTH` samples that are still needed. A buffered sample is never overwritten before the last frame that uses it has read it.
- R6: A reset during operation discards all buffered samples and any partly emitted frame. Frames after the reset contain only samples accepted after the reset.
- R7: After A ≥ `FRAME_LEN` samples have been accepted since reset and the input then stops, exactly ⌊(A − `FRAME_LEN`)/`HOP`⌋ + 1 frames are emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Block can take a sample this cycle |
| in_sample | input | 16 | Signed input sample |
| out_valid | output | 1 | Windowed sample present |
| out_sample | output | 16 | Signed windowed sample |
| out_sof | output | 1 | First sample of a frame |
| out_eof | output | 1 | Last sample of a frame |

## Verification
Frame reads are issued one clock edge after the buffer holds `FRAME_LEN` samples. Each read passes through one register stage for the buffer and table and one for the multiply. As a result, the first `out_sof` appears 3 edges after the accepting edge, and every later sample appears 2 edges after its read is issued. The bench notes the edge number of each fill and requires the first start-of-frame flag at exactly that edge plus 3. It judges acceptance half a cycle before each rising edge and samples all outputs on falling edges. It rebuilds every expected windowed value from its own log of accepted samples and its own taper arithmetic, and checks each expected frame count only once the output has gone quiet.

// File: rtl/ftp_pkg.sv
package ftp_pkg;

  localparam int SAMPLE_W  = 16;
  localparam int COEF_FRAC = 15;
  localparam int COEF_W    = COEF_FRAC + 1;
  localparam int PROD_W    = SAMPLE_W + COEF_W + 1;

  // Hamming taper in unsigned Q1.15, rounded half up.
  function automatic int unsigned hamming_q15(input int unsigned n, input int unsigned len);
    real ang;
    real w;
    ang = 2.0 * 3.14159265358979 * real'(n) / real'(len - 1);
    w   = 0.54 - 0.46 * $cos(ang);
    return $unsigned($rtoi(w * 32768.0 + 0.5));
  endfunction

  // Signed sample times unsigned coefficient, rounded back to sample width.
  function automatic logic signed [SAMPLE_W-1:0] apply_taper(
    input logic signed [SAMPLE_W-1:0] s,
    input logic        [COEF_W-1:0]   c
  );
    logic signed [PROD_W-1:0] prod;
    logic signed [PROD_W-1:0] rnd;
    prod = PROD_W'(s) * $signed({1'b0, c});
    rnd  = (prod + (PROD_W'(1) <<< (COEF_FRAC - 1))) >>> COEF_FRAC;
    return rnd[SAMPLE_W-1:0];
  endfunction

endpackage

// File: rtl/ftp_coef_rom.sv
module ftp_coef_rom
  import ftp_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  localparam int IDX_W = $clog2(FRAME_LEN)
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  idx,
  output logic [COEF_W-1:0] coef_q
);

  logic [COEF_W-1:0] table_w [FRAME_LEN];

  for (genvar g = 0; g < FRAME_LEN; g++) begin : g_tap
    localparam int unsigned TAP = hamming_q15(g, FRAME_LEN);
    assign table_w[g] = COEF_W'(TAP);
  end

  always_ff @(posedge clk) begin
    coef_q <= table_w[idx];
  end

endmodule

// File: rtl/ftp_sample_ring.sv
module ftp_sample_ring
  import ftp_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic signed [SAMPLE_W-1:0] wr_data,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic signed [SAMPLE_W-1:0] rd_q
);

  logic signed [SAMPLE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_q <= mem[rd_addr];
  end

endmodule

// File: rtl/ftp_frame_sched.sv
module ftp_frame_sched #(
  parameter int FRAME_LEN = 256,
  parameter int HOP       = 100,
  parameter int DEPTH     = 512,
  localparam int IDX_W  = $clog2(FRAME_LEN),
  localparam int ADDR_W = $clog2(DEPTH),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic              issue,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [IDX_W-1:0]  idx,
  output logic              frame_last,
  output logic              buf_full
);

  logic [ADDR_W-1:0] base_q;
  logic [ADDR_W-1:0] wr_ptr_q;
  logic [CNT_W-1:0]  held_q;
  logic [CNT_W-1:0]  held_next;
  logic              active_q;
  logic [IDX_W-1:0]  idx_q;

  assign buf_full   = (held_q == CNT_W'(DEPTH));
  assign in_ready   = !buf_full;
  assign wr_en      = in_valid && in_ready;
  assign wr_addr    = wr_ptr_q;
  assign issue      = active_q;
  assign idx        = idx_q;
  assign rd_addr    = base_q + ADDR_W'(idx_q);
  assign frame_last = active_q && (idx_q == IDX_W'(FRAME_LEN - 1));

  always_comb begin
    held_next = held_q;
    if (wr_en)      held_next = held_next + CNT_W'(1);
    if (frame_last) held_next = held_next - CNT_W'(HOP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      wr_ptr_q <= '0;
      held_q   <= '0;
      active_q <= 1'b0;
      idx_q    <= '0;
    end else begin
      held_q <= held_next;
      if (wr_en)      wr_ptr_q <= wr_ptr_q + ADDR_W'(1);
      if (frame_last) base_q   <= base_q + ADDR_W'(HOP);
      if (!active_q) begin
        if (held_q >= CNT_W'(FRAME_LEN)) begin
          active_q <= 1'b1;
          idx_q    <= '0;
        end
      end else if (frame_last) begin
        active_q <= (held_next >= CNT_W'(FRAME_LEN));
        idx_q    <= '0;
      end else begin
        idx_q <= idx_q + IDX_W'(1);
      end
    end
  end

endmodule

// File: rtl/frame_taper.sv
module frame_taper
  import ftp_pkg::*;
#(
  parameter int FRAME_LEN = 256,
  parameter int HOP       = 100,
  parameter int DEPTH     = 512
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  output logic                       in_ready,
  input  logic signed [SAMPLE_W-1:0] in_sample,
  output logic                       out_valid,
  output logic signed [SAMPLE_W-1:0] out_sample,
  output logic                       out_sof,
  output logic                       out_eof
);

  localparam int IDX_W  = $clog2(FRAME_LEN);
  localparam int ADDR_W = $clog2(DEPTH);

  // Named internal events (observed by the checker)
  logic              wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic              issue;
  logic [ADDR_W-1:0] rd_addr;
  logic [IDX_W-1:0]  idx;
  logic              frame_last;
  logic              buf_full;

  logic signed [SAMPLE_W-1:0] ring_q;
  logic [COEF_W-1:0]          coef_q;
  logic                       s1_valid;
  logic                       s1_sof;
  logic                       s1_eof;

  ftp_frame_sched #(
    .FRAME_LEN(FRAME_LEN), .HOP(HOP), .DEPTH(DEPTH)
  ) u_sched (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .wr_en(wr_en), .wr_addr(wr_addr), .issue(issue), .rd_addr(rd_addr),
    .idx(idx), .frame_last(frame_last), .buf_full(buf_full)
  );

  ftp_sample_ring #(.DEPTH(DEPTH)) u_ring (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(in_sample),
    .rd_addr(rd_addr), .rd_q(ring_q)
  );

  ftp_coef_rom #(.FRAME_LEN(FRAME_LEN)) u_rom (
    .clk(clk), .idx(idx), .coef_q(coef_q)
  );

  // Stage 1: buffer and table read
  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_sof   <= 1'b0;
      s1_eof   <= 1'b0;
    end else begin
      s1_valid <= issue;
      s1_sof   <= issue && (idx == '0);
      s1_eof   <= frame_last;
    end
  end

  // Stage 2: multiply and round
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      out_sample <= '0;
    end else begin
      out_valid  <= s1_valid;
      out_sof    <= s1_sof;
      out_eof    <= s1_eof;
      out_sample <= s1_valid ? apply_taper(ring_q, coef_q) : '0;
    end
  end

endmodule

// File: rtl/ftp_checker.sv
module ftp_checker #(
  parameter int FRAME_LEN = 256,
  localparam int CW = $clog2(FRAME_LEN + 1)
) (
  input logic clk,
  input logic rst,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid,
  input logic out_sof,
  input logic out_eof,
  input logic buf_full
);

  logic [CW-1:0] accepted_q;
  logic [CW-1:0] in_frame_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      accepted_q <= '0;
      in_frame_q <= '0;
    end else begin
      if (in_valid && in_ready && accepted_q != CW'(FRAME_LEN))
        accepted_q <= accepted_q + CW'(1);
      if (out_valid) in_frame_q <= out_eof ? '0 : in_frame_q + CW'(1);
    end
  end

  p_quiet_until_fill_r1: assert property (@(posedge clk) disable iff (rst)
    (accepted_q != CW'(FRAME_LEN)) |-> !out_valid);

  p_sof_marks_start_r2: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> (out_valid && in_frame_q == '0));

  p_eof_at_end_r2: assert property (@(posedge clk) disable iff (rst)
    out_eof |-> (out_valid && in_frame_q == CW'(FRAME_LEN - 1)));

  p_no_gap_in_frame_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_eof) |=> out_valid);

  p_next_is_start_r2: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_eof) |=> (!out_valid || out_sof));

  p_stall_when_full_r5: assert property (@(posedge clk) disable iff (rst)
    buf_full |-> !in_ready);

endmodule

bind frame_taper ftp_checker #(.FRAME_LEN(FRAME_LEN)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_sof(out_sof), .out_eof(out_eof),
  .buf_full(buf_full)
);

// File: tb/frame_taper_tb.sv
module frame_taper_tb;

  localparam int N     = 256;
  localparam int HOP   = 100;
  localparam int DEPTH = 512;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_sample = '0;
  logic out_valid;
  logic signed [15:0] out_sample;
  logic out_sof;
  logic out_eof;

  always #4 clk = ~clk;

  frame_taper #(.FRAME_LEN(N), .HOP(HOP), .DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .out_valid(out_valid), .out_sample(out_sample),
    .out_sof(out_sof), .out_eof(out_eof)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  logic signed [15:0] sent [0:8191];
  int n_sent    = 0;
  int seg_base  = 0;
  int fill_edge = -1;
  int mon_frame = 0;
  int mon_idx   = 0;
  int seg_outs  = 0;
  int ready_low = 0;
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic signed [15:0] exp_taper(input logic signed [15:0] s, input int n);
    real w;
    longint c;
    longint p;
    w = 0.54 - 0.46 * $cos(2.0 * 3.14159265358979 * real'(n) / real'(N - 1));
    c = longint'($rtoi(w * 32768.0 + 0.5));
    p = longint'(s) * c + 64'sd16384;
    return 16'(p >>> 15);
  endfunction

  function automatic logic signed [15:0] gen_value(input int k);
    if (k % 7 == 0) return 16'sd32767;
    if (k % 7 == 3) return -16'sd32768;
    return 16'(k * 40503 + 17);
  endfunction

  // Output monitor: compares against the logged input stream
  always @(negedge clk) begin
    if (!rst) begin
      if (out_valid) begin
        int pos;
        logic signed [15:0] e;
        pos = mon_frame * HOP + mon_idx;
        chk(pos < (n_sent - seg_base), "R3", "frame sample not yet accepted", pos, n_sent - seg_base);
        e = exp_taper(sent[seg_base + pos], mon_idx);
        chk(out_sample == e, "R4", "windowed value", out_sample, e);
        chk(out_sof == (mon_idx == 0), "R2", "sof flag", out_sof, mon_idx == 0);
        chk(out_eof == (mon_idx == N - 1), "R2", "eof flag", out_eof, mon_idx == N - 1);
        if (mon_frame == 0 && mon_idx == 0)
          chk(cyc == fill_edge + 3, "R1", "first sof latency edge", cyc, fill_edge + 3);
        seg_outs++;
        if (mon_idx == N - 1) begin
          mon_idx = 0;
          mon_frame++;
        end else begin
          mon_idx++;
        end
      end else if (mon_idx != 0) begin
        chk(1'b0, "R2", "gap inside frame at index", mon_idx, -1);
      end
    end
  end

  task automatic send(input int count, input bit gapped);
    int k;
    k = 0;
    while (k < count) begin
      @(negedge clk);
      in_valid  = gapped ? lfsr[0] : 1'b1;
      lfsr      = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      in_sample = gen_value(n_sent);
      #2;
      if (in_valid && in_ready) begin
        sent[n_sent] = in_sample;
        n_sent++;
        k++;
        if (n_sent - seg_base == N) fill_edge = cyc + 1;
      end else if (in_valid) begin
        ready_low++;
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    #1;
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    seg_base  = n_sent;
    mon_frame = 0;
    mon_idx   = 0;
    seg_outs  = 0;
    fill_edge = -1;
    rst = 1'b0;
  endtask

  function automatic int exp_frames();
    int a;
    a = n_sent - seg_base;
    return (a < N) ? 0 : (a - N) / HOP + 1;
  endfunction

  always @(posedge clk) begin
    if (cyc == LIMIT) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, LIMIT);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

    // Segment A: fill just short of a frame, then full-rate and gapped traffic
    send(N - 1, 1'b0);
    repeat (50) @(negedge clk);
    chk(seg_outs == 0, "R1", "outputs before fill", seg_outs, 0);
    send(1 + HOP * 10, 1'b0);
    chk(ready_low > 0, "R5", "backpressure cycles at full rate", ready_low, 1);
    send(600, 1'b1);
    repeat (3000) @(negedge clk);
    chk(mon_frame == exp_frames(), "R7", "frame count after flush", mon_frame, exp_frames());
    chk(mon_idx == 0, "R2", "partial frame after flush", mon_idx, 0);
    chk(seg_outs == mon_frame * N, "R2", "output sample count", seg_outs, mon_frame * N);

    // Segment B: reset while frames are in flight
    send(300, 1'b0);
    repeat (20) @(negedge clk);
    do_reset();
    @(negedge clk);
    chk(out_valid == 1'b0, "R6", "out_valid after mid-stream reset", out_valid, 0);
    chk(in_ready == 1'b1, "R6", "in_ready after mid-stream reset", in_ready, 1);
    send(N - 1, 1'b1);
    repeat (50) @(negedge clk);
    chk(seg_outs == 0, "R6", "outputs before refill", seg_outs, 0);
    send(1 + 2 * HOP, 1'b1);
    repeat (2000) @(negedge clk);
    chk(mon_frame == exp_frames(), "R7", "frame count after reset", mon_frame, exp_frames());
    chk(mon_frame == 3, "R6", "frames from new samples only", mon_frame, 3);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

endmodule